// File: doc/BRIEF.md
# Multi-PHY Port Polling Master

This block is the master side of a shared multi-PHY cell bus. It drives a 5-bit PHY address onto the bus and samples eight cell-available lines. Each line is a sub-port of the addressed port. From the samples it keeps a per-port, per-sub-port table of which PHYs currently have room or data. A downstream cell selector reads that table. The transmit and receive directions each own a copy of the same polling engine, with its own address bus, its own cell-available lines and its own table. Both copies share one configuration: a connected-port bitmap and a connected-sub-port mask.

The poll walks the connected ports in ascending order and wraps to the lowest one. It never presents address 31, which is reserved as the idle (null) address. The address is presented in one cycle. On the following clock edge the cell-available lines are sampled, qualified by the sub-port mask, and stored for that port. The bus clock is an input and the block does not generate it.

Configuration arrives through a byte-wide write port. Register indices 0 to 3 hold the connected-port bitmap, and index 4 holds the sub-port mask.

Top module: `mphy_poll_master`

## Requirements
- R1: Asynchronous reset (rst_ni low) sets both address outputs to 31. It clears every table entry, so both avail outputs read 0. It sets the connected-port bitmap to all ones and the sub-port mask to 0x01.
- R2: On each rising edge out of reset, each address output moves to the lowest connected port strictly above its current value. If there is none, it wraps to the lowest connected port. Port 31 and ports whose bitmap bit is 0 are skipped. The bitmap used is the one held before that edge.
- R3: When an address p other than 31 is on a path's address output, the next rising edge stores that path's cell-available lines for port p. Bit n holds sub-port n.
- R4: A stored bit n is 1 only if the sub-port mask bit n held before that edge was 1. Masked-off lines are stored as 0.
- R5: When bitmap bits 0 to 30 are all zero, the next edge sets both address outputs to 31. No table entry is updated while the address is 31.
- R6: A write with cfg_we_i high at index k in 0..3 replaces bitmap bits 8k+7..8k with cfg_wdata_i. A write at index 4 replaces the sub-port mask. Writes at indices 5 to 7 change nothing. A write takes effect at the edge it is sampled on, after that edge's address step.
- R7: The transmit and receive paths poll and store independently. Each uses only its own cell-available lines, and both follow the same configuration.
- R8: The avail outputs show the stored entry of port rd_port_i. They read 0 when that port's bitmap bit is 0 or when rd_port_i is 31.
- R9: A table entry holds its value on every edge where its port is not the presented address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, supplied externally |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register index |
| cfg_wdata_i | input | 8 | Configuration write data |
| tx_addr_o | output | 5 | Transmit-side polled PHY address |
| tx_clav_i | input | 8 | Transmit-side cell-available lines, one per sub-port |
| rx_addr_o | output | 5 | Receive-side polled PHY address |
| rx_clav_i | input | 8 | Receive-side cell-available lines, one per sub-port |
| rd_port_i | input | 5 | Port whose status the selector reads |
| tx_avail_o | output | 8 | Transmit status of rd_port_i, one bit per sub-port |
| rx_avail_o | output | 8 | Receive status of rd_port_i, one bit per sub-port |

## Verification
Three things can happen on the same edge: a configuration write, an address step, and a table store for the port being left. The step and the store must use the bitmap and mask held before the write. The bench provokes this by issuing bitmap and mask writes on random cycles while polling continues with random cell-available patterns. Its reference model applies the step and the store first and the write last. The selector can also read the port that is being stored on that same edge. The read port sweeps over every address, so this collision happens repeatedly, and the model requires the new value to appear only after the edge.

// File: rtl/mphy_poll_pkg.sv
package mphy_poll_pkg;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned N_SUB      = 8;
  localparam int unsigned CFG_ADDR_W = 3;
  localparam int unsigned CFG_DATA_W = 8;
  localparam int unsigned N_PORTS    = 1 << ADDR_W;
  localparam int unsigned N_BYTES    = N_PORTS / CFG_DATA_W;
  localparam int unsigned N_PATHS    = 2;
  localparam int unsigned PATH_TX    = 0;
  localparam int unsigned PATH_RX    = 1;
endpackage

// File: rtl/mphy_cfg_regs.sv
module mphy_cfg_regs #(
  parameter int unsigned N_PORTS    = 32,
  parameter int unsigned N_SUB      = 8,
  parameter int unsigned CFG_ADDR_W = 3,
  parameter int unsigned CFG_DATA_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [CFG_ADDR_W-1:0] addr_i,
  input  logic [CFG_DATA_W-1:0] wdata_i,
  output logic [N_PORTS-1:0]    port_list_o,
  output logic [N_SUB-1:0]      sub_mask_o
);
  localparam int unsigned N_BYTES  = N_PORTS / CFG_DATA_W;
  localparam int unsigned MASK_IDX = N_BYTES;

  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        port_list_o[b*CFG_DATA_W +: CFG_DATA_W] <= '1;
      else if (we_i && addr_i == CFG_ADDR_W'(b))
        port_list_o[b*CFG_DATA_W +: CFG_DATA_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      sub_mask_o <= N_SUB'(1);
    else if (we_i && addr_i == CFG_ADDR_W'(MASK_IDX))
      sub_mask_o <= wdata_i[N_SUB-1:0];
  end
endmodule

// File: rtl/mphy_poll_engine.sv
module mphy_poll_engine #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [(1<<ADDR_W)-1:0]   port_list_i,
  output logic [ADDR_W-1:0]        addr_o
);
  localparam int unsigned N_PORTS  = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] NULL_ADDR = ADDR_W'(N_PORTS - 1);

  logic [ADDR_W-1:0] nxt_addr;
  logic              hit_above;
  logic              hit_any;
  logic [ADDR_W-1:0] first_above;
  logic [ADDR_W-1:0] first_any;

  // two priority scans: first connected port above current, first overall
  always_comb begin
    hit_above   = 1'b0;
    hit_any     = 1'b0;
    first_above = NULL_ADDR;
    first_any   = NULL_ADDR;
    for (int i = 0; i < int'(N_PORTS) - 1; i++) begin
      if (port_list_i[i]) begin
        if (!hit_any) begin
          hit_any   = 1'b1;
          first_any = ADDR_W'(i);
        end
        if (!hit_above && ADDR_W'(i) > addr_o) begin
          hit_above   = 1'b1;
          first_above = ADDR_W'(i);
        end
      end
    end
    if (hit_above)    nxt_addr = first_above;
    else if (hit_any) nxt_addr = first_any;
    else              nxt_addr = NULL_ADDR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_o <= NULL_ADDR;
    else         addr_o <= nxt_addr;
  end
endmodule

// File: rtl/mphy_avail_table.sv
module mphy_avail_table #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned N_SUB  = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      poll_addr_i,
  input  logic [N_SUB-1:0]       clav_i,
  input  logic [N_SUB-1:0]       sub_mask_i,
  input  logic [(1<<ADDR_W)-1:0] port_list_i,
  input  logic [ADDR_W-1:0]      rd_port_i,
  output logic [N_SUB-1:0]       avail_o
);
  localparam int unsigned N_PORTS  = 1 << ADDR_W;
  localparam int unsigned N_ENTRY  = N_PORTS - 1;
  localparam logic [ADDR_W-1:0] NULL_ADDR = ADDR_W'(N_PORTS - 1);

  logic [N_SUB-1:0] entry_q [N_ENTRY];
  logic [N_SUB-1:0] clav_ok;

  assign clav_ok = clav_i & sub_mask_i;

  for (genvar p = 0; p < N_ENTRY; p++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        entry_q[p] <= '0;
      else if (poll_addr_i == ADDR_W'(p))
        entry_q[p] <= clav_ok;
    end
  end

  always_comb begin
    avail_o = '0;
    for (int p = 0; p < int'(N_ENTRY); p++) begin
      if (rd_port_i == ADDR_W'(p) && port_list_i[p])
        avail_o = entry_q[p];
    end
    if (rd_port_i == NULL_ADDR) avail_o = '0;
  end
endmodule

// File: rtl/mphy_poll_master.sv
module mphy_poll_master
  import mphy_poll_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [CFG_ADDR_W-1:0] cfg_addr_i,
  input  logic [CFG_DATA_W-1:0] cfg_wdata_i,
  output logic [ADDR_W-1:0]     tx_addr_o,
  input  logic [N_SUB-1:0]      tx_clav_i,
  output logic [ADDR_W-1:0]     rx_addr_o,
  input  logic [N_SUB-1:0]      rx_clav_i,
  input  logic [ADDR_W-1:0]     rd_port_i,
  output logic [N_SUB-1:0]      tx_avail_o,
  output logic [N_SUB-1:0]      rx_avail_o
);
  logic [N_PORTS-1:0]               port_list;
  logic [N_SUB-1:0]                 sub_mask;
  logic [N_PATHS-1:0][ADDR_W-1:0]   path_addr;
  logic [N_PATHS-1:0][N_SUB-1:0]    path_clav;
  logic [N_PATHS-1:0][N_SUB-1:0]    path_avail;

  mphy_cfg_regs #(
    .N_PORTS(N_PORTS), .N_SUB(N_SUB),
    .CFG_ADDR_W(CFG_ADDR_W), .CFG_DATA_W(CFG_DATA_W)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .port_list_o(port_list), .sub_mask_o(sub_mask)
  );

  assign path_clav[PATH_TX] = tx_clav_i;
  assign path_clav[PATH_RX] = rx_clav_i;

  for (genvar g = 0; g < N_PATHS; g++) begin : g_path
    mphy_poll_engine #(.ADDR_W(ADDR_W)) u_engine (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .port_list_i(port_list), .addr_o(path_addr[g])
    );
    mphy_avail_table #(.ADDR_W(ADDR_W), .N_SUB(N_SUB)) u_table (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .poll_addr_i(path_addr[g]), .clav_i(path_clav[g]),
      .sub_mask_i(sub_mask), .port_list_i(port_list),
      .rd_port_i(rd_port_i), .avail_o(path_avail[g])
    );
  end

  assign tx_addr_o  = path_addr[PATH_TX];
  assign rx_addr_o  = path_addr[PATH_RX];
  assign tx_avail_o = path_avail[PATH_TX];
  assign rx_avail_o = path_avail[PATH_RX];
endmodule

// File: rtl/mphy_poll_master_chk.sv
module mphy_poll_master_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned N_SUB  = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [(1<<ADDR_W)-1:0] port_list,
  input logic [N_SUB-1:0]       sub_mask,
  input logic [ADDR_W-1:0]      tx_addr_o,
  input logic [ADDR_W-1:0]      rx_addr_o,
  input logic [N_SUB-1:0]       tx_clav_i,
  input logic [N_SUB-1:0]       rx_clav_i,
  input logic [ADDR_W-1:0]      rd_port_i,
  input logic [N_SUB-1:0]       tx_avail_o,
  input logic [N_SUB-1:0]       rx_avail_o
);
  localparam int unsigned N_PORTS = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] NULL_ADDR = ADDR_W'(N_PORTS - 1);

  logic [N_PORTS-1:0] list_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) list_d <= '1;
    else         list_d <= port_list;
  end

  p_addr_connected_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_addr_o != NULL_ADDR |-> list_d[tx_addr_o]);
  p_rx_addr_connected_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_addr_o != NULL_ADDR |-> list_d[rx_addr_o]);
  p_null_when_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    list_d[N_PORTS-2:0] == '0 |-> (tx_addr_o == NULL_ADDR && rx_addr_o == NULL_ADDR));
  p_store_sample_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tx_addr_o) != NULL_ADDR && rd_port_i == $past(tx_addr_o) && port_list[rd_port_i])
    |-> tx_avail_o == ($past(tx_clav_i) & $past(sub_mask)));
  p_mask_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rx_addr_o) != NULL_ADDR && rd_port_i == $past(rx_addr_o) && port_list[rd_port_i])
    |-> (rx_avail_o & ~$past(sub_mask)) == '0);
  p_read_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_port_i == NULL_ADDR || !port_list[rd_port_i]) |-> (tx_avail_o == '0 && rx_avail_o == '0));
endmodule

bind mphy_poll_master mphy_poll_master_chk #(.ADDR_W(5), .N_SUB(8)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .port_list(port_list), .sub_mask(sub_mask),
  .tx_addr_o(tx_addr_o), .rx_addr_o(rx_addr_o),
  .tx_clav_i(tx_clav_i), .rx_clav_i(rx_clav_i), .rd_port_i(rd_port_i),
  .tx_avail_o(tx_avail_o), .rx_avail_o(rx_avail_o)
);

// File: tb/mphy_poll_master_bench.sv
`timescale 1ns/1ps
module mphy_poll_master_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] waddr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] tx_clav = '0, rx_clav = '0;
  logic [4:0] rd_port = '0;
  logic [4:0] tx_addr, rx_addr;
  logic [7:0] tx_avail, rx_avail;

  always #5 clk = ~clk;

  mphy_poll_master u_mphy_poll_master (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(waddr), .cfg_wdata_i(wdata),
    .tx_addr_o(tx_addr), .tx_clav_i(tx_clav), .rx_addr_o(rx_addr), .rx_clav_i(rx_clav),
    .rd_port_i(rd_port), .tx_avail_o(tx_avail), .rx_avail_o(rx_avail)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference model
  logic [31:0] m_list;
  logic [7:0]  m_mask;
  int          m_addr [2];
  logic [7:0]  m_tbl  [2][32];

  function automatic int next_port(int cur, logic [31:0] lst);
    for (int i = cur + 1; i < 31; i++) if (lst[i]) return i;
    for (int i = 0; i < 31; i++) if (lst[i]) return i;
    return 31;
  endfunction

  function automatic logic [7:0] exp_avail(int path, int p);
    if (p == 31 || !m_list[p]) return 8'h00;
    return m_tbl[path][p];
  endfunction

  task automatic model_reset();
    m_list = '1; m_mask = 8'h01; m_addr[0] = 31; m_addr[1] = 31;
    for (int q = 0; q < 2; q++) for (int p = 0; p < 32; p++) m_tbl[q][p] = '0;
  endtask

  task automatic model_edge();
    if (m_addr[0] != 31) m_tbl[0][m_addr[0]] = tx_clav & m_mask;
    if (m_addr[1] != 31) m_tbl[1][m_addr[1]] = rx_clav & m_mask;
    m_addr[0] = next_port(m_addr[0], m_list);
    m_addr[1] = next_port(m_addr[1], m_list);
    if (we) begin
      if (waddr < 3'd4) m_list[waddr*8 +: 8] = wdata;
      else if (waddr == 3'd4) m_mask = wdata;
    end
  endtask

  task automatic check(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compare();
    check("tx_addr", tx_addr, m_addr[0]);
    check("rx_addr", rx_addr, m_addr[1]);
    check("tx_avail", tx_avail, exp_avail(0, rd_port));
    check("rx_avail", rx_avail, exp_avail(1, rd_port));
  endtask

  // inputs set at negedge; model steps on posedge; compare at next negedge
  task automatic cycle(bit w, logic [2:0] a, logic [7:0] d,
                       logic [7:0] tc, logic [7:0] rc, logic [4:0] rp);
    we = w; waddr = a; wdata = d; tx_clav = tc; rx_clav = rc; rd_port = rp;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++)
      cycle(1'b0, 3'd0, 8'd0, 8'($urandom), 8'($urandom), 5'(k % 32));
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    cycle(1'b1, a, d, 8'($urandom), 8'($urandom), 5'($urandom));
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; compare();

    tag = "R2_R3_R9"; run(70);
    tag = "R7";       run(40);
    tag = "R4_R6";    wr(3'd4, 8'hA5); run(70);
    tag = "R2_R6";
    wr(3'd0, 8'h81); wr(3'd1, 8'h00); wr(3'd2, 8'h10); wr(3'd3, 8'hC0);
    run(40);
    tag = "R6_ignore"; wr(3'd5, 8'h00); wr(3'd6, 8'h00); wr(3'd7, 8'hFF); run(20);
    tag = "R8";
    for (int p = 0; p < 32; p++) cycle(1'b0, 3'd0, 8'd0, 8'hFF, 8'hFF, 5'(p));
    tag = "R5";
    wr(3'd0, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h80); run(40);
    tag = "R2_single"; wr(3'd1, 8'h04); run(20);
    tag = "R6_collide";
    for (int k = 0; k < 300; k++)
      cycle(($urandom % 3) == 0, 3'($urandom % 6), 8'($urandom),
            8'($urandom), 8'($urandom), 5'($urandom));
    tag = "R1_rerun";
    @(negedge clk) rst_n = 1'b0;
    model_reset();
    @(negedge clk); compare();
    rst_n = 1'b1;
    run(40);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule